// File: doc/BRIEF.md
# Presettable Cascadable Up/Down Counter

This block is a synchronous binary counter built from 4-bit digit stages. Each digit can be preset from a parallel data word, counted up or down, or held. Everything changes on the rising clock edge. A synchronous active-high reset clears the count to zero.

Every stage has two active-low count enables. The parallel enable is shared by all digits. The carry enable arrives from the digit below and also qualifies that stage's active-low terminal-count flag. The flag is decoded combinationally from the current digit, the direction and the carry enable. The top module chains `STAGES` digits: each flag drives the carry enable of the next more significant digit, and the load, direction, parallel enable and clock are common to all. The result is one wide synchronous counter whose last flag marks the end of the whole range.

Top module: `updn_chain`

## Requirements
- R1: A high `rst` at a rising edge clears the whole count to 0. Reset takes priority over load and count.
- R2: With `rst` low and `load_n` low at a rising edge, `q` takes the value of `din`. The levels of both count enables do not matter.
- R3: With `rst` and `load_n` inactive, `q` holds its value across an edge if `en_par_n` or `en_car_n` is high.
- R4: With `load_n` high and both enables low, `up` = 1 adds one at each edge, and the all-ones count wraps to 0.
- R5: With `load_n` high and both enables low, `up` = 0 subtracts one at each edge, and 0 wraps to all ones.
- R6: A 4-bit digit drives `tc_n` low, in the same cycle, exactly when `en_car_n` is low and the digit is 15 with `up` = 1, or 0 with `up` = 0. `en_par_n` has no effect on `tc_n`.
- R7: Each digit's flag feeds the next digit's carry enable. The chain therefore counts as one 4·STAGES-bit counter with R4/R5 wrap, and the final `tc_n` is low when `en_car_n` is low and the full count is all ones going up, or zero going down.
- R8: A single digit follows this sequence: preset 13; count up through 14, 15, 0, 1, 2; with the count inhibited it stays at 2; count down through 1, 0, 15, 14, 13.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high, clears the count |
| load_n | input | 1 | Parallel preset, active low |
| up | input | 1 | Direction: 1 counts up, 0 counts down |
| en_par_n | input | 1 | Count enable common to all digits, active low |
| en_car_n | input | 1 | Carry-in enable of the lowest digit, active low |
| din | input | 4*STAGES | Preset value |
| q | output | 4*STAGES | Current count |
| tc_n | output | 1 | Terminal count of the most significant digit, active low |

## Verification
The bench presets a value while both enables are inactive, and presets while the enables are active. A design that let the enables gate the preset would keep the old count. It raises the parallel enable while a digit sits at its terminal value. A flag wrongly gated by that enable would go high and stall every digit above. It crosses digit boundaries in both directions (0x0F to 0x10 and back, all ones to zero and back). A chain that passed carry with the wrong terminal decode, or ignored direction in that decode, would bump the upper digit at the wrong time. A long pseudo-random stretch compares both a one-digit and a two-digit instance against an arithmetic model on every cycle.

// File: rtl/updn_pkg.sv
package updn_pkg;

  localparam int DIGIT_W = 4;

  typedef logic [DIGIT_W-1:0] digit_t;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_LOAD  = 2'd1,
    OP_COUNT = 2'd2,
    OP_CLEAR = 2'd3
  } op_e;

  // Next value of a digit in the selected direction, wrapping at both ends.
  function automatic digit_t digit_step(input digit_t v, input logic dir_up);
    digit_t one;
    one = digit_t'(1);
    return dir_up ? digit_t'(v + one) : digit_t'(v - one);
  endfunction

  // True when the digit sits at the last value before a wrap in that direction.
  function automatic logic digit_at_end(input digit_t v, input logic dir_up);
    return dir_up ? (v == {DIGIT_W{1'b1}}) : (v == {DIGIT_W{1'b0}});
  endfunction

endpackage

// File: rtl/updn_ctrl.sv
module updn_ctrl
  import updn_pkg::*;
(
  input  logic rst,
  input  logic load_n,
  input  logic en_par_n,
  input  logic en_car_n,
  output op_e  op
);

  // Priority: clear, then preset, then count, else hold.
  always_comb begin
    if (rst)                         op = OP_CLEAR;
    else if (!load_n)                op = OP_LOAD;
    else if (!en_par_n && !en_car_n) op = OP_COUNT;
    else                             op = OP_HOLD;
  end

endmodule

// File: rtl/updn_stage.sv
module updn_stage
  import updn_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   load_n,
  input  logic   up,
  input  logic   en_par_n,
  input  logic   en_car_n,
  input  digit_t din,
  output digit_t q,
  output logic   tc_n
);

  op_e  op;
  logic load_fire;
  logic count_fire;
  logic hold_fire;
  logic at_end;

  updn_ctrl u_ctrl (
    .rst      (rst),
    .load_n   (load_n),
    .en_par_n (en_par_n),
    .en_car_n (en_car_n),
    .op       (op)
  );

  assign load_fire  = (op == OP_LOAD);
  assign count_fire = (op == OP_COUNT);
  assign hold_fire  = (op == OP_HOLD);

  // Terminal decode: state, direction and carry enable only.
  assign at_end = digit_at_end(q, up);
  assign tc_n   = ~(at_end & ~en_car_n);

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: q <= '0;
      OP_LOAD:  q <= din;
      OP_COUNT: q <= digit_step(q, up);
      default:  q <= q;
    endcase
  end

  a_r1_clear: assert property (@(posedge clk)
    rst |=> (q == '0));

  a_r2_load: assert property (@(posedge clk) disable iff (rst)
    load_fire |=> (q == $past(din)));

  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    hold_fire |=> $stable(q));

  a_r4_up_step: assert property (@(posedge clk) disable iff (rst)
    (count_fire && up) |=> (q == digit_t'($past(q) + 1'b1)));

  a_r5_down_step: assert property (@(posedge clk) disable iff (rst)
    (count_fire && !up) |=> (q == digit_t'($past(q) - 1'b1)));

  a_r6_tc_needs_carry: assert property (@(posedge clk) disable iff (rst)
    !tc_n |-> !en_car_n);

endmodule

// File: rtl/updn_chain.sv
module updn_chain
  import updn_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        load_n,
  input  logic                        up,
  input  logic                        en_par_n,
  input  logic                        en_car_n,
  input  logic [STAGES*DIGIT_W-1:0]   din,
  output logic [STAGES*DIGIT_W-1:0]   q,
  output logic                        tc_n
);

  localparam int W = STAGES * DIGIT_W;
  localparam logic [W-1:0] ONE = W'(1);

  // carry_n[g] is the carry enable into digit g; carry_n[g+1] is its flag.
  logic [STAGES:0] carry_n;
  logic            chain_count;

  assign carry_n[0]  = en_car_n;
  assign tc_n        = carry_n[STAGES];
  assign chain_count = !rst && load_n && !en_par_n && !en_car_n;

  for (genvar g = 0; g < STAGES; g++) begin : g_digit
    updn_stage u_stg (
      .clk      (clk),
      .rst      (rst),
      .load_n   (load_n),
      .up       (up),
      .en_par_n (en_par_n),
      .en_car_n (carry_n[g]),
      .din      (din[g*DIGIT_W +: DIGIT_W]),
      .q        (q[g*DIGIT_W +: DIGIT_W]),
      .tc_n     (carry_n[g+1])
    );
  end

  a_r7_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (chain_count && up && !tc_n) |=> (q == '0));

  a_r7_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (chain_count && !up && !tc_n) |=> (q == '1));

  a_r7_wide_up: assert property (@(posedge clk) disable iff (rst)
    (chain_count && up) |=> (q == W'($past(q) + ONE)));

  a_r7_wide_down: assert property (@(posedge clk) disable iff (rst)
    (chain_count && !up) |=> (q == W'($past(q) - ONE)));

endmodule

// File: tb/updn_chain_bench.sv
module updn_chain_bench;

  localparam int N  = 2;
  localparam int WC = 4 * N;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1, load_n = 1'b1, up = 1'b1;
  logic          en_par_n = 1'b1, en_car_n = 1'b1;
  logic [WC-1:0] din = '0;
  logic [WC-1:0] q_c;
  logic          tc_c;
  logic [3:0]    q_s;
  logic          tc_s;
  int            m_c = 0, m_s = 0;
  int            n_tests = 0, n_fail = 0;
  bit            done = 0;

  updn_chain #(.STAGES(N)) u_updn_chain (
    .clk(clk), .rst(rst), .load_n(load_n), .up(up), .en_par_n(en_par_n),
    .en_car_n(en_car_n), .din(din), .q(q_c), .tc_n(tc_c));

  updn_chain #(.STAGES(1)) u_single (
    .clk(clk), .rst(rst), .load_n(load_n), .up(up), .en_par_n(en_par_n),
    .en_car_n(en_car_n), .din(din[3:0]), .q(q_s), .tc_n(tc_s));

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic int mdl_next(input int v, input int w, input int dval);
    int span;
    span = 1 << w;
    if (rst)                         return 0;
    if (!load_n)                     return dval % span;
    if (!en_par_n && !en_car_n)      return up ? (v + 1) % span : (v + span - 1) % span;
    return v;
  endfunction

  function automatic int mdl_tc(input int v, input int w);
    if (en_car_n) return 1;
    if (up)       return (v == (1 << w) - 1) ? 0 : 1;
    return (v == 0) ? 0 : 1;
  endfunction

  task automatic check_flags(input string tag);
    #1;
    chk({tag, " tc chain"},  int'(tc_c), mdl_tc(m_c, WC));
    chk({tag, " tc single"}, int'(tc_s), mdl_tc(m_s, 4));
  endtask

  task automatic cycle(input string tag);
    int nc, ns;
    nc = mdl_next(m_c, WC, int'(din));
    ns = mdl_next(m_s, 4, int'(din[3:0]));
    @(posedge clk);
    @(negedge clk);
    m_c = nc;
    m_s = ns;
    chk({tag, " q chain"},  int'(q_c), m_c);
    chk({tag, " q single"}, int'(q_s), m_s);
    check_flags(tag);
  endtask

  task automatic t_reset();
    rst = 1'b1; load_n = 1'b0; din = 8'hA5; en_par_n = 1'b0; en_car_n = 1'b0;
    cycle("R1 reset beats load");
    cycle("R1 reset");
    chk("R1 single cleared", int'(q_s), 0);
    chk("R1 chain cleared", int'(q_c), 0);
    rst = 1'b0; load_n = 1'b1; en_par_n = 1'b1; en_car_n = 1'b1;
  endtask

  task automatic t_sequence();
    int seq_up[5]   = '{14, 15, 0, 1, 2};
    int seq_down[5] = '{1, 0, 15, 14, 13};
    din = 8'h3D; load_n = 1'b0; en_par_n = 1'b1; en_car_n = 1'b1;
    cycle("R2 load with enables idle");
    chk("R8 preset 13", int'(q_s), 13);
    load_n = 1'b1; en_par_n = 1'b0; en_car_n = 1'b0; up = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cycle("R4 up");
      chk("R8 up sequence", int'(q_s), seq_up[i]);
      chk("R6 tc at 15 going up", int'(tc_s), (seq_up[i] == 15) ? 0 : 1);
    end
    en_par_n = 1'b1;
    cycle("R3 hold par");
    chk("R8 inhibit holds 2", int'(q_s), 2);
    en_par_n = 1'b0; en_car_n = 1'b1;
    cycle("R3 hold carry");
    chk("R3 carry high holds", int'(q_s), 2);
    en_car_n = 1'b0; up = 1'b0;
    check_flags("R6 direction change");
    for (int i = 0; i < 5; i++) begin
      cycle("R5 down");
      chk("R8 down sequence", int'(q_s), seq_down[i]);
      chk("R6 tc at 0 going down", int'(tc_s), (seq_down[i] == 0) ? 0 : 1);
    end
  endtask

  task automatic t_tc_par();
    din = 8'h00; load_n = 1'b0; en_par_n = 1'b1; en_car_n = 1'b1;
    cycle("R2 preset zero");
    load_n = 1'b1; up = 1'b0; en_car_n = 1'b0; en_par_n = 1'b1;
    #1;
    chk("R6 tc ignores par enable", int'(tc_s), 0);
    chk("R7 chain tc at zero down", int'(tc_c), 0);
    cycle("R3 held at zero");
    en_car_n = 1'b1;
    #1 chk("R6 carry high blocks tc", int'(tc_s), 1);
    en_car_n = 1'b0; up = 1'b1;
    #1 chk("R6 zero not terminal up", int'(tc_s), 1);
  endtask

  task automatic t_load_beats_count();
    din = 8'h96; load_n = 1'b0; en_par_n = 1'b0; en_car_n = 1'b0; up = 1'b1;
    cycle("R2 load over count");
    chk("R2 chain preset", int'(q_c), 8'h96);
    chk("R2 single preset", int'(q_s), 6);
    load_n = 1'b1;
  endtask

  task automatic t_chain_carry();
    en_par_n = 1'b0; en_car_n = 1'b0;
    din = 8'h0F; load_n = 1'b0; cycle("R2 preset 0F");
    load_n = 1'b1; up = 1'b1; cycle("R7 carry up");
    chk("R7 0F to 10", int'(q_c), 8'h10);
    up = 1'b0; cycle("R7 borrow down");
    chk("R7 10 to 0F", int'(q_c), 8'h0F);
    din = 8'hFF; load_n = 1'b0; cycle("R2 preset FF");
    load_n = 1'b1; up = 1'b1;
    #1 chk("R7 tc at all ones", int'(tc_c), 0);
    cycle("R7 wrap up");
    chk("R7 FF to 00", int'(q_c), 0);
    up = 1'b0;
    #1 chk("R7 tc at zero", int'(tc_c), 0);
    cycle("R7 wrap down");
    chk("R7 00 to FF", int'(q_c), 8'hFF);
  endtask

  task automatic t_soak();
    logic [15:0] lfsr = 16'hACE1;
    for (int i = 0; i < 400; i++) begin
      lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      load_n   = !(lfsr[3:0] == 4'd0);
      en_par_n = lfsr[6] & lfsr[5];
      en_car_n = lfsr[8] & lfsr[7] & lfsr[9];
      up       = lfsr[11] | lfsr[12];
      din      = lfsr[15:8] ^ lfsr[7:0];
      rst      = (lfsr[15:10] == 6'd0);
      check_flags("R7 soak flags");
      cycle("R7 soak");
    end
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    t_reset();
    t_sequence();
    t_tc_par();
    t_load_beats_count();
    t_chain_carry();
    t_soak();
    done = 1;
    summary();
    $finish;
  end

endmodule